// File: doc/BRIEF.md
# Timeslice-Group Runlist Scheduler

This block walks a runlist, which is a flat list of 128-bit entries in a memory outside the block. The list is divided into group records. Each record starts with a header entry, and the header gives the group's ID, its timeslice and how many channel entries follow it. The block reads each channel entry and hands it to an engine queue through a valid/acknowledge handshake. After the group's last channel is accepted, the group holds the engines for its timeslice. The block then moves on to the next record. After the last entry of the list it wraps back to the first.

Software points the block at a list by writing a base address and an entry count. A scheduler-disable input stops new groups from starting but lets the running group finish. A preempt request names either a group or a channel. If it matches the running group, the block raises a pending flag and ends that group's slice early.

Top module: `tsg_runlist_sched`

## Requirements
- R1: Bit 0 of an entry is 1 for a group header and 0 for a channel entry. A header gives the scale in bits [19:16], the timeout in [31:24], the member count in [39:32] and the group ID in [75:64]. A channel entry gives the queue selector in bit 1, the aperture in [5:4] and the channel ID in [75:64]. The dispatched aperture equals the entry's field.
- R2: The block dispatches exactly as many channel entries as the header's count, in list order, and then reads the next header. A header with count 0 grants no timeslice.
- R3: After the entry at offset length-1 the walk continues at offset 0. A length of 0 leaves the block idle, with no entry reads.
- R4: A running group keeps `run_active` high for (timeout << scale) * P + 1 cycles, where P = 1024 / CLK_NS. `run_tsgid` shows the ID of that group.
- R5: A queue selector value of NQ or more is dispatched on queue 0. Any other value is dispatched on its own queue.
- R6: While `disp_valid` is high and `disp_ack` is low, the dispatch fields stay stable on the next cycle.
- R7: A preempt request that matches the current group raises `pre_pending` on the next cycle. A request matches if its type is 1 and its ID is the group's ID, or its type is 0 and its ID is the group's most recently read channel. The running slice ends on the cycle after that, and `pre_pending` clears at the same time.
- R8: A preempt request that names neither the current group nor its current channel leaves `pre_pending` low and the slice running.
- R9: While `sched_dis` is 1, no new group starts: no entry reads and no dispatches occur once the current group has ended.
- R10: Reset clears `disp_valid`, `rd_en`, `run_active` and `pre_pending`.
- R11: A configuration write restarts the walk at the entry at the new base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for base and length |
| cfg_base | input | AW | Address of the first runlist entry |
| cfg_len | input | 16 | Number of entries in the runlist |
| sched_dis | input | 1 | 1 stops new groups from starting |
| pre_valid | input | 1 | Preempt request strobe |
| pre_type | input | 1 | 0 = channel ID, 1 = group ID |
| pre_id | input | 12 | ID named by the preempt request |
| pre_pending | output | 1 | Preempt of the current group in progress |
| rd_en | output | 1 | Entry read request |
| rd_addr | output | AW | Entry read address |
| rd_data | input | 128 | Entry read data, valid one cycle after `rd_en` |
| disp_valid | output | 1 | Channel dispatch offered |
| disp_ack | input | 1 | Engine accepts the dispatch |
| disp_chid | output | 12 | Dispatched channel ID |
| disp_queue | output | QW | Engine queue for the channel |
| disp_aperture | output | 2 | Aperture field of the channel |
| disp_tsgid | output | 12 | Group that owns the dispatched channel |
| run_active | output | 1 | A group holds the engines |
| run_tsgid | output | 12 | ID of the group that holds the engines |

## Verification
The assertions assume that the read port always returns the addressed entry on the cycle after `rd_en`. They also assume that configuration writes happen only while the block is idle or disabled. The stimulus keeps a model memory that answers every read with a fixed one-cycle latency. It changes the base and length only after `sched_dis` has held the walker idle long enough for the current group to end. Preempt requests are one-cycle pulses, sent while a group is running. The engine acknowledge follows a rotating delay, so that held dispatches are exercised.

// File: rtl/tsg_runlist_sched.sv
module tsg_runlist_sched #(
  parameter int AW = 16,
  parameter int NQ = 1,
  parameter int CLK_NS = 256,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_base,
  input  logic [15:0]   cfg_len,
  input  logic          sched_dis,
  input  logic          pre_valid,
  input  logic          pre_type,
  input  logic [11:0]   pre_id,
  output logic          pre_pending,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [127:0]  rd_data,
  output logic          disp_valid,
  input  logic          disp_ack,
  output logic [11:0]   disp_chid,
  output logic [QW-1:0] disp_queue,
  output logic [1:0]    disp_aperture,
  output logic [11:0]   disp_tsgid,
  output logic          run_active,
  output logic [11:0]   run_tsgid
);
  localparam int PRE = (1024 + CLK_NS - 1) / CLK_NS;
  localparam int PW  = $clog2(PRE + 1);
  localparam int UW  = 23;

  typedef enum logic [2:0] {S_IDLE, S_HRD, S_HWT, S_CRD, S_CWT, S_DISP, S_RUN} st_t;
  st_t st;

  logic [AW-1:0] base;
  logic [15:0]   len, idx, nidx;
  logic [11:0]   tsg, chid;
  logic [7:0]    left;
  logic [UW-1:0] units;
  logic [PW-1:0] pcnt;
  logic [QW-1:0] q_r;
  logic [1:0]    ap_r;
  logic          live, chan_live, pend, hit, run_end;

  assign nidx = (idx + 16'd1 == len) ? 16'd0 : idx + 16'd1;
  assign hit  = pre_valid && live &&
                (pre_type ? (pre_id == tsg) : (chan_live && pre_id == chid));
  assign run_end = (st == S_RUN) && (units == '0 || pend);

  assign rd_en         = (st == S_HRD) || (st == S_CRD);
  assign rd_addr       = base + AW'(idx);
  assign disp_valid    = (st == S_DISP);
  assign disp_chid     = chid;
  assign disp_queue    = q_r;
  assign disp_aperture = ap_r;
  assign disp_tsgid    = tsg;
  assign run_active    = (st == S_RUN);
  assign run_tsgid     = tsg;
  assign pre_pending   = pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; base <= '0; len <= '0; idx <= '0;
      tsg <= '0; chid <= '0; left <= '0; units <= '0; pcnt <= '0;
      q_r <= '0; ap_r <= '0; live <= 1'b0; chan_live <= 1'b0; pend <= 1'b0;
    end else if (cfg_we) begin
      base <= cfg_base; len <= cfg_len; idx <= '0;
      st <= S_IDLE; live <= 1'b0; chan_live <= 1'b0; pend <= 1'b0;
    end else begin
      if (run_end) pend <= 1'b0;
      else if (hit) pend <= 1'b1;
      case (st)
        S_IDLE: if (len != 16'd0 && !sched_dis) st <= S_HRD;
        S_HRD:  st <= S_HWT;
        S_HWT: begin
          idx <= nidx;
          if (!rd_data[0] || rd_data[39:32] == 8'd0) begin
            st <= S_IDLE;
          end else begin
            tsg   <= rd_data[75:64];
            left  <= rd_data[39:32];
            units <= UW'(rd_data[31:24]) << rd_data[19:16];
            live  <= 1'b1;
            chan_live <= 1'b0;
            st    <= S_CRD;
          end
        end
        S_CRD: st <= S_CWT;
        S_CWT: begin
          idx       <= nidx;
          chid      <= rd_data[75:64];
          ap_r      <= rd_data[5:4];
          q_r       <= (int'(rd_data[1]) < NQ) ? QW'(rd_data[1]) : '0;
          chan_live <= 1'b1;
          st        <= S_DISP;
        end
        S_DISP: if (disp_ack) begin
          left <= left - 8'd1;
          if (left == 8'd1) begin
            pcnt <= PW'(PRE - 1);
            st   <= S_RUN;
          end else begin
            st <= S_CRD;
          end
        end
        S_RUN: begin
          if (run_end) begin
            st <= S_IDLE; live <= 1'b0; chan_live <= 1'b0;
          end else if (pcnt == '0) begin
            units <= units - UW'(1);
            pcnt  <= PW'(PRE - 1);
          end else begin
            pcnt <= pcnt - PW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  idle_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len == 16'd0) |-> !rd_en);

  // R6
  hold_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ack && !cfg_we) |=>
      (disp_valid && $stable(disp_chid) && $stable(disp_queue) && $stable(disp_tsgid)));

  // R5
  queue_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (int'(disp_queue) < NQ));

  // R9
  start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HRD && $past(st) == S_IDLE && !$past(cfg_we)) |-> !$past(sched_dis));

  // R7
  preempt_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_active && pre_pending && !cfg_we) |=> (!run_active && !pre_pending));

  // R8
  pending_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_pending |-> live);
endmodule

// File: tb/tsg_runlist_sched_test.sv
module tsg_runlist_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int P = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, sched_dis = 1'b0, pre_valid = 1'b0, pre_type = 1'b0;
  logic [15:0] cfg_base = '0, cfg_len = '0;
  logic [11:0] pre_id = '0;
  logic pre_pending, rd_en, disp_valid, run_active;
  logic disp_ack = 1'b0;
  logic [15:0] rd_addr;
  logic [127:0] rd_data = '0;
  logic [11:0] disp_chid, disp_tsgid, run_tsgid;
  logic [0:0] disp_queue;
  logic [1:0] disp_aperture;

  tsg_runlist_sched #(.AW(16), .NQ(1), .CLK_NS(256)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_len(cfg_len),
    .sched_dis(sched_dis), .pre_valid(pre_valid), .pre_type(pre_type), .pre_id(pre_id),
    .pre_pending(pre_pending), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .disp_valid(disp_valid), .disp_ack(disp_ack), .disp_chid(disp_chid),
    .disp_queue(disp_queue), .disp_aperture(disp_aperture), .disp_tsgid(disp_tsgid),
    .run_active(run_active), .run_tsgid(run_tsgid));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [127:0] mem [0:15];
  always @(posedge clk) rd_data <= mem[rd_addr[3:0]];

  int checks = 0, errors = 0;
  int ex_ch[0:3], ex_q[0:3], ex_ap[0:3], ex_tsg[0:3];
  int ex_n = 1, ex_pos = 0;
  int ndisp = 0, nslice = 0, rd_cnt = 0, pre_hits = 0, pre_used = 0;
  int ack_ctr = 0, run_len = 0, last_tsg = 0;
  bit was_run = 0, prev_hold = 0;
  logic [11:0] prev_ch, prev_tsg;
  logic [0:0] prev_q;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [127:0] hdr(int id, int sc, int to, int cnt);
    logic [127:0] e = '0;
    e[0] = 1'b1; e[19:16] = 4'(sc); e[31:24] = 8'(to); e[39:32] = 8'(cnt); e[75:64] = 12'(id);
    return e;
  endfunction

  function automatic logic [127:0] chan(int id, int sel, int ap);
    logic [127:0] e = '0;
    e[1] = 1'(sel); e[5:4] = 2'(ap); e[75:64] = 12'(id); e[127:96] = 32'h5a5a_1234;
    return e;
  endfunction

  function automatic int exp_units(int id);
    case (id)
      5: return 2 << 1;
      7: return 3;
      30: return 200 << 4;
      default: return -1;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_en) rd_cnt++;
      if (prev_hold) begin
        // R6
        chk(disp_valid && disp_chid == prev_ch && disp_tsgid == prev_tsg && disp_queue == prev_q,
            "R6", int'(disp_chid), int'(prev_ch));
      end
      disp_ack = disp_valid && (ack_ctr % 3 == 2);
      ack_ctr = disp_valid ? ack_ctr + 1 : 0;
      prev_hold = disp_valid && !disp_ack;
      prev_ch = disp_chid; prev_tsg = disp_tsgid; prev_q = disp_queue;
      if (disp_valid && disp_ack) begin
        // R1 R2 R3 R5
        chk(int'(disp_chid) == ex_ch[ex_pos], "R2", int'(disp_chid), ex_ch[ex_pos]);
        chk(int'(disp_queue) == ex_q[ex_pos], "R5", int'(disp_queue), ex_q[ex_pos]);
        chk(int'(disp_aperture) == ex_ap[ex_pos], "R1", int'(disp_aperture), ex_ap[ex_pos]);
        chk(int'(disp_tsgid) == ex_tsg[ex_pos], "R1", int'(disp_tsgid), ex_tsg[ex_pos]);
        last_tsg = ex_tsg[ex_pos];
        ex_pos = (ex_pos + 1) % ex_n;
        ndisp++;
      end
      if (run_active) begin
        if (!was_run) begin
          // R4
          chk(int'(run_tsgid) == last_tsg, "R4", int'(run_tsgid), last_tsg);
          run_len = 0;
        end
        run_len++;
        was_run = 1;
      end else if (was_run) begin
        was_run = 0;
        nslice++;
        if (pre_hits != pre_used) pre_used = pre_hits;
        else chk(run_len == exp_units(last_tsg) * P + 1, "R4", run_len, exp_units(last_tsg) * P + 1);
      end
    end else begin
      disp_ack = 1'b0;
    end
  end

  task automatic preempt(input bit ty, input int id);
    @(negedge clk);
    pre_valid = 1'b1; pre_type = ty; pre_id = 12'(id);
    @(negedge clk);
    pre_valid = 1'b0;
  endtask

  task automatic cfg(input int b, input int l);
    @(negedge clk);
    cfg_we = 1'b1; cfg_base = 16'(b); cfg_len = 16'(l);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int snap_rd, snap_d;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10
    chk(!disp_valid && !rd_en && !run_active && !pre_pending, "R10",
        int'({disp_valid, rd_en, run_active, pre_pending}), 0);
    rst_n = 1'b1;

    cfg(0, 0);
    snap_rd = rd_cnt;
    repeat (30) @(negedge clk);
    // R3
    chk(rd_cnt == snap_rd, "R3", rd_cnt - snap_rd, 0);

    mem[0] = hdr(5, 1, 2, 2);
    mem[1] = chan(10, 0, 1);
    mem[2] = chan(11, 1, 3);
    mem[3] = hdr(7, 0, 3, 1);
    mem[4] = chan(20, 0, 2);
    mem[5] = hdr(9, 2, 5, 0);
    ex_ch[0] = 10; ex_q[0] = 0; ex_ap[0] = 1; ex_tsg[0] = 5;
    ex_ch[1] = 11; ex_q[1] = 0; ex_ap[1] = 3; ex_tsg[1] = 5;
    ex_ch[2] = 20; ex_q[2] = 0; ex_ap[2] = 2; ex_tsg[2] = 7;
    ex_n = 3; ex_pos = 0;
    cfg(0, 6);
    while (ndisp < 9 || nslice < 6) @(negedge clk);

    sched_dis = 1'b1;
    repeat (120) @(negedge clk);
    snap_rd = rd_cnt; snap_d = ndisp;
    repeat (60) @(negedge clk);
    // R9
    chk(rd_cnt == snap_rd && ndisp == snap_d && !run_active, "R9", rd_cnt - snap_rd, 0);

    mem[8] = hdr(30, 4, 200, 1);
    mem[9] = chan(40, 0, 2);
    ex_ch[0] = 40; ex_q[0] = 0; ex_ap[0] = 2; ex_tsg[0] = 30;
    ex_n = 1; ex_pos = 0;
    // R11
    cfg(8, 2);
    sched_dis = 1'b0;
    while (!run_active) @(negedge clk);
    repeat (5) @(negedge clk);

    preempt(1'b1, 31);
    // R8
    chk(!pre_pending && run_active, "R8", int'(pre_pending), 0);
    pre_hits++;
    preempt(1'b1, 30);
    // R7
    chk(pre_pending && run_active, "R7", int'(pre_pending), 1);
    @(negedge clk);
    chk(!run_active && !pre_pending, "R7", int'({run_active, pre_pending}), 0);

    while (!run_active) @(negedge clk);
    repeat (3) @(negedge clk);
    preempt(1'b0, 30);
    // R8
    chk(!pre_pending && run_active, "R8", int'(pre_pending), 0);
    pre_hits++;
    preempt(1'b0, 40);
    // R7
    chk(pre_pending && run_active, "R7", int'(pre_pending), 1);
    @(negedge clk);
    chk(!run_active && !pre_pending, "R7", int'({run_active, pre_pending}), 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule